// File: doc/BRIEF.md
# Interval Performance History Store

This block gathers link quality statistics for a framed transmission line. Upstream logic decides, once per second, whether that second was errored, unavailable, bursty-errored or severely-errored. It also flags controlled slips and loss-of-frame occurrences. Each decision arrives as a one-cycle strobe. The block counts these strobes over the current fifteen-minute interval. When an interval tick arrives, it files the finished counts into a ring of 96 records and starts the next interval from zero.

A day tick copies the running 24-hour totals to a set of day registers that hold steady until the next day tick. At the same moment it latches the number of intervals that were marked good during that day. Every counter stops at its largest value and never wraps. The slip and loss-of-frame counts are 8 bits each and are packed into one 16-bit word.

A host reads the history one record at a time. It selects a category and starts a burst, which presents the newest record. Each step after that presents the next older record. The host can wipe the unavailable-second history and the bursty-second history. A wipe request aimed at any other category is ignored.

Top module: `perf_history_store`

## Requirements
- R1: Every 16-bit count (interval counts for UAS/BES/SES and the day totals for ES/UAS/BES/SES) stops at 65535 and holds there while further events arrive.
- R2: The slip and loss-of-frame counts are 8 bits each and saturate at 255 independently of each other. The packed word carries the slip count in bits 7:0 and the loss-of-frame count in bits 15:8, both in history records and in `day_slip_lof`.
- R3: On a cycle with `ivl_tick` high, the counts gathered before that cycle are filed as a new history record. A strobe in the tick cycle itself is counted as the first event of the new interval.
- R4: The history holds the 96 most recent records. A 97th record overwrites the oldest one. Stepping 96 times from the newest record returns to the newest record.
- R5: `rd_sel` selects the category that `rd_data` shows: 0 = UAS, 1 = BES, 2 = SES, 3 = packed slip/LOF. After a cycle with `rd_start` high, `rd_data` shows the newest record, including one filed in that same cycle. Each cycle with `rd_step` high (and `rd_start` low) moves to the next older record.
- R6: A record position that was never filled, or that was wiped, reads as zero.
- R7: On a cycle with `day_tick` high, the day outputs take the running totals gathered before that cycle, and the running totals restart. A strobe in the tick cycle counts toward the new day.
- R8: `day_valid_ivl` takes, at a day tick, the number of interval ticks that had `ivl_good` high since the previous day tick. An interval tick in the same cycle as the day tick is included. The count saturates at 255.
- R9: `clr_hist` with `rd_sel` 0 or 1 wipes the whole history of that category, so it reads as zero. With `rd_sel` 2 or 3 it has no effect. If a record is filed in the same cycle as a wipe, the new record survives.
- R10: After reset, `rd_data` and all day outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_es | input | 1 | Errored-second strobe |
| ev_uas | input | 1 | Unavailable-second strobe |
| ev_bes | input | 1 | Bursty-errored-second strobe |
| ev_ses | input | 1 | Severely-errored-second strobe |
| ev_css | input | 1 | Controlled-slip-second strobe |
| ev_lof | input | 1 | Loss-of-frame strobe |
| ivl_tick | input | 1 | End of a fifteen-minute interval |
| ivl_good | input | 1 | Interval ending now is valid |
| day_tick | input | 1 | End of a 24-hour period |
| clr_hist | input | 1 | Wipe the history selected by rd_sel (UAS/BES only) |
| rd_sel | input | 2 | History category select |
| rd_start | input | 1 | Point the reader at the newest record |
| rd_step | input | 1 | Move the reader one record older |
| rd_data | output | 16 | Selected record field |
| day_es | output | 16 | Day total of errored seconds |
| day_uas | output | 16 | Day total of unavailable seconds |
| day_bes | output | 16 | Day total of bursty-errored seconds |
| day_ses | output | 16 | Day total of severely-errored seconds |
| day_slip_lof | output | 16 | Day slip count in bits 7:0, loss-of-frame count in bits 15:8 |
| day_valid_ivl | output | 8 | Good intervals in the previous day |

## Verification
The bench drives the slip strobe long enough to pin its 8-bit field at 255 while the loss-of-frame field stays small. A design that let the two packed fields carry into each other would return a corrupted word there. It also holds the UAS strobe for more than 65535 cycles, which catches a counter that wraps back to a small value. Strobes that coincide with interval and day ticks are checked, because a design that drops or misfiles that one event is off by one. The bench also reads past the 96-record boundary, to catch a reader that wraps at a power of two, and reads an empty history, where a design without per-record valid tracking would return stale data. Finally it checks that wipes aimed at the SES and slip histories leave them intact, and that the good-interval total counts an interval tick that lands on the day tick.

// File: rtl/ihs_pkg.sv
package ihs_pkg;
  localparam int CNT_W      = 16;
  localparam int SUB_W      = 8;
  localparam int HIST_DEPTH = 96;
  localparam int NSET       = 4;
  localparam int SEL_W      = 2;

  // Categories that the host is allowed to wipe (bit index = rd_sel code)
  localparam logic [NSET-1:0] CLEARABLE = 4'b0011;

  typedef enum logic [SEL_W-1:0] {
    SEL_UAS  = 2'd0,
    SEL_BES  = 2'd1,
    SEL_SES  = 2'd2,
    SEL_SLIP = 2'd3
  } hist_sel_e;

  typedef struct packed {
    logic [CNT_W-1:0] uas;
    logic [CNT_W-1:0] bes;
    logic [CNT_W-1:0] ses;
    logic [SUB_W-1:0] lof;
    logic [SUB_W-1:0] css;
  } ivl_rec_t;
endpackage

// File: rtl/ihs_sat_ctr.sv
module ihs_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // restart loads this cycle's event as the first count of the new period
  always_comb begin
    cnt_en = restart | (inc & (cnt_q != MAXV));
    if (restart) cnt_d = {{(W-1){1'b0}}, inc};
    else         cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ihs_history.sv
module ihs_history
  import ihs_pkg::*;
#(
  parameter int DEPTH = HIST_DEPTH,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  ivl_rec_t         wr_rec,
  input  logic             clr_en,
  input  logic [SEL_W-1:0] clr_sel,
  input  logic             rd_start,
  input  logic             rd_step,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [CNT_W-1:0] rd_data
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  ivl_rec_t         mem [DEPTH];
  logic [DEPTH-1:0] vld_q [NSET];
  logic [DEPTH-1:0] vld_d [NSET];
  logic [IW-1:0]    head_q, head_d;
  logic [IW-1:0]    ptr_q, ptr_d;
  ivl_rec_t         rec;
  logic [CNT_W-1:0] field;

  function automatic logic [IW-1:0] older(input logic [IW-1:0] idx);
    return (idx == '0) ? LAST : idx - 1'b1;
  endfunction

  always_comb begin
    head_d = head_q;
    if (wr_en) head_d = (head_q == LAST) ? '0 : head_q + 1'b1;
    ptr_d = ptr_q;
    if (rd_start)     ptr_d = older(head_d);
    else if (rd_step) ptr_d = older(ptr_q);
  end

  // wipe first, then a same-cycle write marks its slot valid again
  always_comb begin
    for (int s = 0; s < NSET; s++) begin
      vld_d[s] = vld_q[s];
      if (clr_en && (clr_sel == SEL_W'(s))) vld_d[s] = '0;
      if (wr_en) vld_d[s][head_q] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      ptr_q  <= '0;
      for (int s = 0; s < NSET; s++) vld_q[s] <= '0;
    end else begin
      head_q <= head_d;
      ptr_q  <= ptr_d;
      for (int s = 0; s < NSET; s++) vld_q[s] <= vld_d[s];
    end
  end

  // record storage carries no reset; the valid bits mask its contents
  always_ff @(posedge clk) begin
    if (wr_en) mem[head_q] <= wr_rec;
  end

  always_comb begin
    rec = mem[ptr_q];
    case (hist_sel_e'(rd_sel))
      SEL_UAS:  field = rec.uas;
      SEL_BES:  field = rec.bes;
      SEL_SES:  field = rec.ses;
      default:  field = {rec.lof, rec.css};
    endcase
    rd_data = vld_q[rd_sel][ptr_q] ? field : '0;
  end
endmodule

// File: rtl/perf_history_store.sv
module perf_history_store
  import ihs_pkg::*;
#(
  parameter int DEPTH = HIST_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_es,
  input  logic             ev_uas,
  input  logic             ev_bes,
  input  logic             ev_ses,
  input  logic             ev_css,
  input  logic             ev_lof,
  input  logic             ivl_tick,
  input  logic             ivl_good,
  input  logic             day_tick,
  input  logic             clr_hist,
  input  logic [1:0]       rd_sel,
  input  logic             rd_start,
  input  logic             rd_step,
  output logic [15:0]      rd_data,
  output logic [15:0]      day_es,
  output logic [15:0]      day_uas,
  output logic [15:0]      day_bes,
  output logic [15:0]      day_ses,
  output logic [15:0]      day_slip_lof,
  output logic [7:0]       day_valid_ivl
);
  localparam int N_IVL16 = 3;   // uas, bes, ses
  localparam int N_DAY16 = 4;   // es, uas, bes, ses
  localparam int N_SUB   = 2;   // css, lof
  localparam logic [SUB_W-1:0] VMAX = {SUB_W{1'b1}};

  logic [N_IVL16-1:0] ev_ivl16;
  logic [N_DAY16-1:0] ev_day16;
  logic [N_SUB-1:0]   ev_sub;

  logic [CNT_W-1:0] cur16 [N_IVL16];
  logic [SUB_W-1:0] cur8  [N_SUB];
  logic [CNT_W-1:0] acc16 [N_DAY16];
  logic [SUB_W-1:0] acc8  [N_SUB];

  logic [CNT_W-1:0] day16_q [N_DAY16];
  logic [SUB_W-1:0] day8_q  [N_SUB];

  logic [SUB_W-1:0] vacc_q, vacc_d, vsum, vday_q;
  logic             vinc;
  ivl_rec_t         rec;
  logic             clr_en;

  assign ev_ivl16 = {ev_ses, ev_bes, ev_uas};
  assign ev_day16 = {ev_ses, ev_bes, ev_uas, ev_es};
  assign ev_sub   = {ev_lof, ev_css};

  // current-interval counters
  generate
    for (genvar i = 0; i < N_IVL16; i++) begin : g_ivl16
      ihs_sat_ctr #(.W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .inc(ev_ivl16[i]),
        .restart(ivl_tick), .cnt(cur16[i]));
    end
    for (genvar i = 0; i < N_SUB; i++) begin : g_ivl8
      ihs_sat_ctr #(.W(SUB_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .inc(ev_sub[i]),
        .restart(ivl_tick), .cnt(cur8[i]));
    end
  endgenerate

  // running day accumulators
  generate
    for (genvar i = 0; i < N_DAY16; i++) begin : g_day16
      ihs_sat_ctr #(.W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .inc(ev_day16[i]),
        .restart(day_tick), .cnt(acc16[i]));
    end
    for (genvar i = 0; i < N_SUB; i++) begin : g_day8
      ihs_sat_ctr #(.W(SUB_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .inc(ev_sub[i]),
        .restart(day_tick), .cnt(acc8[i]));
    end
  endgenerate

  // good-interval tally; a tick landing on the day tick belongs to the old day
  always_comb begin
    vinc   = ivl_tick & ivl_good;
    vsum   = (vinc && (vacc_q != VMAX)) ? vacc_q + 1'b1 : vacc_q;
    vacc_d = day_tick ? '0 : vsum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vacc_q <= '0;
    else        vacc_q <= vacc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_DAY16; i++) day16_q[i] <= '0;
      for (int i = 0; i < N_SUB; i++)   day8_q[i]  <= '0;
      vday_q <= '0;
    end else if (day_tick) begin
      for (int i = 0; i < N_DAY16; i++) day16_q[i] <= acc16[i];
      for (int i = 0; i < N_SUB; i++)   day8_q[i]  <= acc8[i];
      vday_q <= vsum;
    end
  end

  always_comb begin
    rec.uas = cur16[0];
    rec.bes = cur16[1];
    rec.ses = cur16[2];
    rec.css = cur8[0];
    rec.lof = cur8[1];
    clr_en  = clr_hist & CLEARABLE[rd_sel];
  end

  ihs_history #(.DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ivl_tick), .wr_rec(rec),
    .clr_en(clr_en), .clr_sel(rd_sel),
    .rd_start(rd_start), .rd_step(rd_step), .rd_sel(rd_sel),
    .rd_data(rd_data));

  assign day_es        = day16_q[0];
  assign day_uas       = day16_q[1];
  assign day_bes       = day16_q[2];
  assign day_ses       = day16_q[3];
  assign day_slip_lof  = {day8_q[1], day8_q[0]};
  assign day_valid_ivl = vday_q;
endmodule

// File: rtl/ihs_checker.sv
module ihs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_uas,
  input logic        ivl_tick,
  input logic        day_tick,
  input logic        clr_hist,
  input logic [1:0]  rd_sel,
  input logic        rd_start,
  input logic        rd_step,
  input logic [15:0] rd_data,
  input logic [15:0] cur_uas,
  input logic [15:0] acc_uas,
  input logic [15:0] day_uas
);
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_uas == 16'hFFFF && !ivl_tick) |=> (cur_uas == 16'hFFFF)); // R1

  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_tick |=> (cur_uas == {15'd0, $past(ev_uas)})); // R3

  AST_DAY_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    day_tick |=> (day_uas == $past(acc_uas))); // R7

  AST_WIPE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hist && rd_sel == 2'd0 && !ivl_tick && !rd_start && !rd_step)
      |=> (rd_sel != 2'd0 || rd_data == 16'd0)); // R9

  AST_WIPE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hist && rd_sel == 2'd2 && !ivl_tick && !rd_start && !rd_step)
      |=> (rd_sel != 2'd2 || $stable(rd_data))); // R9
endmodule

bind perf_history_store ihs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ev_uas(ev_uas), .ivl_tick(ivl_tick),
  .day_tick(day_tick), .clr_hist(clr_hist), .rd_sel(rd_sel),
  .rd_start(rd_start), .rd_step(rd_step), .rd_data(rd_data),
  .cur_uas(cur16[0]), .acc_uas(acc16[1]), .day_uas(day_uas));

// File: tb/tb_perf_history_store.sv
module tb_perf_history_store;
  localparam int D = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev [6];   // es, uas, bes, ses, css, lof
  logic ivl_tick, ivl_good, day_tick, clr_hist, rd_start, rd_step;
  logic [1:0] rd_sel;
  logic [15:0] rd_data, day_es, day_uas, day_bes, day_ses, day_slip_lof;
  logic [7:0] day_valid_ivl;

  always #2.5 clk = ~clk;

  perf_history_store dut (
    .clk(clk), .rst_n(rst_n),
    .ev_es(ev[0]), .ev_uas(ev[1]), .ev_bes(ev[2]), .ev_ses(ev[3]),
    .ev_css(ev[4]), .ev_lof(ev[5]),
    .ivl_tick(ivl_tick), .ivl_good(ivl_good), .day_tick(day_tick),
    .clr_hist(clr_hist), .rd_sel(rd_sel), .rd_start(rd_start), .rd_step(rd_step),
    .rd_data(rd_data), .day_es(day_es), .day_uas(day_uas), .day_bes(day_bes),
    .day_ses(day_ses), .day_slip_lof(day_slip_lof), .day_valid_ivl(day_valid_ivl));

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model state
  int mh [4][D];
  bit mv [4][D];
  int head = 0, rptr = 0;
  int cur [5];    // uas, bes, ses, css, lof
  int acc [6];    // es, uas, bes, ses, css, lof
  int dayv [6];
  int vacc = 0, vout = 0;

  function automatic int sat(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic int exp_rd(input int sel);
    return mv[sel][rptr] ? mh[sel][rptr] : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_update();
    int s;
    s = int'(rd_sel);
    if (clr_hist && s < 2) for (int i = 0; i < D; i++) mv[s][i] = 0;
    if (ivl_tick) begin
      mh[0][head] = cur[0]; mh[1][head] = cur[1]; mh[2][head] = cur[2];
      mh[3][head] = (cur[4] << 8) | cur[3];
      for (int k = 0; k < 4; k++) mv[k][head] = 1;
      head = (head + 1) % D;
    end
    for (int c = 0; c < 5; c++) begin
      if (ivl_tick) cur[c] = int'(ev[c+1]);
      else if (ev[c+1]) cur[c] = sat(cur[c] + 1, (c < 3) ? 65535 : 255);
    end
    if (day_tick) begin
      for (int c = 0; c < 6; c++) begin dayv[c] = acc[c]; acc[c] = int'(ev[c]); end
      vout = sat(vacc + int'(ivl_tick && ivl_good), 255);
      vacc = 0;
    end else begin
      for (int c = 0; c < 6; c++)
        if (ev[c]) acc[c] = sat(acc[c] + 1, (c < 4) ? 65535 : 255);
      vacc = sat(vacc + int'(ivl_tick && ivl_good), 255);
    end
    if (rd_start)     rptr = (head + D - 1) % D;
    else if (rd_step) rptr = (rptr + D - 1) % D;
  endtask

  task automatic check_all();
    chk(rd_data == 16'(exp_rd(int'(rd_sel))), "R5 rd_data", int'(rd_data), exp_rd(int'(rd_sel)));
    chk(day_es == 16'(dayv[0]), "R7 day_es", int'(day_es), dayv[0]);
    chk(day_uas == 16'(dayv[1]), "R7 day_uas", int'(day_uas), dayv[1]);
    chk(day_bes == 16'(dayv[2]), "R7 day_bes", int'(day_bes), dayv[2]);
    chk(day_ses == 16'(dayv[3]), "R7 day_ses", int'(day_ses), dayv[3]);
    chk(day_slip_lof == 16'((dayv[5] << 8) | dayv[4]), "R2 day_slip_lof",
        int'(day_slip_lof), (dayv[5] << 8) | dayv[4]);
    chk(day_valid_ivl == 8'(vout), "R8 day_valid_ivl", int'(day_valid_ivl), vout);
  endtask

  task automatic idle();
    for (int c = 0; c < 6; c++) ev[c] = 1'b0;
    ivl_tick = 0; ivl_good = 0; day_tick = 0; clr_hist = 0; rd_start = 0; rd_step = 0;
  endtask

  // inputs set at negedge; model follows the edge; outputs sampled at next negedge
  task automatic step(input bit full = 1);
    @(posedge clk);
    model_update();
    @(negedge clk);
    if (full) check_all();
    idle();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int first;
    void'($urandom(32'd20240611));
    for (int c = 0; c < 5; c++) cur[c] = 0;
    for (int c = 0; c < 6; c++) begin acc[c] = 0; dayv[c] = 0; end
    for (int k = 0; k < 4; k++) for (int i = 0; i < D; i++) begin mh[k][i] = 0; mv[k][i] = 0; end
    idle(); rd_sel = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk(rd_data == 16'd0, "R10 rd_data", int'(rd_data), 0);
    chk(day_uas == 16'd0 && day_es == 16'd0 && day_slip_lof == 16'd0, "R10 day totals",
        int'(day_uas), 0);
    chk(day_valid_ivl == 8'd0, "R10 day_valid_ivl", int'(day_valid_ivl), 0);

    // R6: empty history reads zero in every category
    rd_start = 1; step();
    for (int k = 0; k < 4; k++) begin
      rd_sel = 2'(k); rd_step = 1; step();
      chk(rd_data == 16'd0, "R6 empty read", int'(rd_data), 0);
    end

    // R3: event in the tick cycle begins the new interval
    rd_sel = 2'd1;
    repeat (3) begin ev[2] = 1; step(); end
    ev[2] = 1; ivl_tick = 1; step();
    ivl_tick = 1; step();
    rd_start = 1; step();
    chk(rd_data == 16'd1, "R3 newest BES", int'(rd_data), 1);
    rd_step = 1; step();
    chk(rd_data == 16'd3, "R3 older BES", int'(rd_data), 3);

    // random traffic, compared each cycle against the model (R5, R7, R8)
    for (int n = 0; n < 3000; n++) begin
      for (int c = 0; c < 6; c++) ev[c] = ($urandom % 3) == 0;
      ivl_tick = ($urandom % 12) == 0;
      ivl_good = ($urandom % 4) != 0;
      day_tick = ($urandom % 150) == 0;
      clr_hist = ($urandom % 400) == 0;
      rd_sel   = 2'($urandom % 4);
      rd_start = ($urandom % 20) == 0;
      rd_step  = ($urandom % 2) == 0;
      step();
    end

    // R4: wrap around the 96-record ring
    for (int i = 0; i < 100; i++) begin
      for (int j = 0; j < (i % 4); j++) begin ev[3] = 1; step(); end
      ivl_tick = 1; ivl_good = 1; step();
    end
    rd_sel = 2'd2; rd_start = 1; step();
    first = int'(rd_data);
    for (int i = 0; i < D; i++) begin
      rd_step = 1; step(0);
      chk(rd_data == 16'(exp_rd(2)), "R4 ring read", int'(rd_data), exp_rd(2));
    end
    chk(int'(rd_data) == first, "R4 back to newest", int'(rd_data), first);

    // R9: wipe UAS, wipes of SES and slip are ignored
    rd_sel = 2'd0; clr_hist = 1; step();
    rd_start = 1; step();
    for (int i = 0; i < 4; i++) begin
      chk(rd_data == 16'd0, "R9 UAS wiped", int'(rd_data), 0);
      rd_step = 1; step();
    end
    rd_sel = 2'd2; clr_hist = 1; step();
    rd_sel = 2'd3; clr_hist = 1; step();
    rd_sel = 2'd2; rd_start = 1; step();
    chk(rd_data == 16'(exp_rd(2)) && mv[2][rptr], "R9 SES kept", int'(rd_data), exp_rd(2));
    rd_sel = 2'd3; step();
    chk(rd_data == 16'(exp_rd(3)) && mv[3][rptr], "R9 slip kept", int'(rd_data), exp_rd(3));

    // R8: good-interval tally including a tick on the day tick
    day_tick = 1; step();
    ivl_tick = 1; ivl_good = 1; step();
    ivl_tick = 1; ivl_good = 0; step();
    ivl_tick = 1; ivl_good = 1; step();
    ivl_tick = 1; ivl_good = 1; step();
    day_tick = 1; ivl_tick = 1; ivl_good = 1; step();
    chk(day_valid_ivl == 8'd4, "R8 tally", int'(day_valid_ivl), 4);
    for (int i = 0; i < 260; i++) begin ivl_tick = 1; ivl_good = 1; step(0); end
    day_tick = 1; step();
    chk(day_valid_ivl == 8'd255, "R8 saturate", int'(day_valid_ivl), 255);

    // R1, R2: saturation of 16-bit and packed 8-bit counts
    day_tick = 1; ivl_tick = 1; step();
    for (int i = 0; i < 65600; i++) begin
      ev[1] = 1; ev[4] = 1; ev[5] = (i < 10); step(0);
    end
    ivl_tick = 1; step();
    rd_sel = 2'd0; rd_start = 1; step();
    chk(rd_data == 16'hFFFF, "R1 UAS history saturate", int'(rd_data), 65535);
    rd_sel = 2'd3; step();
    chk(rd_data == 16'h0AFF, "R2 packed history", int'(rd_data), 16'h0AFF);
    day_tick = 1; step();
    chk(day_uas == 16'hFFFF, "R1 day UAS saturate", int'(day_uas), 65535);
    chk(day_slip_lof == 16'h0AFF, "R2 packed day", int'(day_slip_lof), 16'h0AFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule